// File: doc/BRIEF.md
# Per-Output Queued Input Cell Buffer

This block sits on one input of a cell switch. Incoming fixed-size cells carry a destination output number. Each cell is filed into a logical queue kept for that output. All queues live in one shared cell memory. Each queue is a linked chain of slots, and unused slots are held on a free list. Because each output has its own queue, a cell stuck behind a busy output never delays cells heading elsewhere.

An external scheduler sees a request vector with one bit per output, set while that output's queue holds cells. It answers with a one-hot grant. In the cycle of a valid grant, the head cell of the chosen queue appears on the output with a valid flag, and the cell leaves the queue on the next clock edge. Upstream is throttled by a ready signal, which falls when every shared slot is occupied.

Top module: `voq_buf`

## Requirements
- R1: After reset all queues are empty: `req` is all zero, `in_ready` is high and `out_valid` is low.
- R2: A cell offered with `in_valid` high while `in_ready` is high is stored in the queue selected by `in_port`. From the next cycle, bit `in_port` of `req` is high.
- R3: Cells bound for the same output leave in the order they arrived.
- R4: When `grant` has exactly one bit k set and queue k is nonempty, the same cycle shows `out_valid` high, `out_port` equal to k and `out_cell` equal to the oldest cell of queue k. That cell is removed at the clock edge.
- R5: A `grant` that is all zero, has two or more bits set, or names an empty queue gives `out_valid` low and removes nothing.
- R6: Cells for one output that is never granted do not prevent cells for other outputs from being delivered when those outputs are granted.
- R7: `in_ready` is low exactly when all NSLOT shared slots hold cells. A cell offered while `in_ready` is low is not stored.
- R8: An accepted cell and a granted removal in the same cycle both take effect. This holds on different queues and on the same queue, including a queue that holds a single cell.
- R9: Slots released by removals are reused. After any mix of traffic and a full drain, exactly NSLOT cells can again be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming cell present |
| in_port | input | $clog2(NPORT) | Destination output of the incoming cell |
| in_cell | input | CELL_W | Incoming cell payload |
| in_ready | output | 1 | High while a free slot exists (backpressure when low) |
| req | output | NPORT | Bit k high while the queue for output k is nonempty |
| grant | input | NPORT | One-hot grant from the scheduler |
| out_valid | output | 1 | Granted head cell present this cycle |
| out_port | output | $clog2(NPORT) | Output whose queue supplied the cell |
| out_cell | output | CELL_W | Head cell of the granted queue |

## Verification
Acceptance of a new cell and removal of a granted cell can fall in the same cycle. The dangerous case is when both hit one queue holding zero or one cell, because the head, tail and link updates then interact. The bench provokes this directly, with an enqueue plus grant on a single-cell queue and on an empty queue, and again at the free-list boundary. It also runs a long pseudo-random phase that mixes both operations at every fill level. Each cycle is judged against a bench model of per-output queues, comparing the delivered cell, port, request vector and ready level.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int VOQ_DEF_PORTS = 4;
  localparam int VOQ_DEF_CELLW = 64;
  localparam int VOQ_DEF_SLOTS = 32;

  typedef enum logic [1:0] {
    GNT_NONE  = 2'd0,
    GNT_ONE   = 2'd1,
    GNT_MULTI = 2'd2
  } gnt_kind_e;
endpackage

// File: rtl/voq_grant_dec.sv
module voq_grant_dec #(
  parameter int NPORT = 4,
  parameter int PW    = 2
) (
  input  logic [NPORT-1:0] grant,
  input  logic [NPORT-1:0] nonempty,
  output logic             deq,
  output logic [PW-1:0]    deq_port
);
  import voq_pkg::*;

  gnt_kind_e    kind;
  logic [PW:0]  ones;
  logic [PW-1:0] idx;

  always_comb begin
    ones = '0;
    idx  = '0;
    for (int k = 0; k < NPORT; k++) begin
      if (grant[k]) begin
        ones = ones + 1'b1;
        idx  = idx | PW'(k);
      end
    end
    if (ones == '0)
      kind = GNT_NONE;
    else if (ones == (PW+1)'(1))
      kind = GNT_ONE;
    else
      kind = GNT_MULTI;
  end

  assign deq      = (kind == GNT_ONE) && ((grant & nonempty) != '0);
  assign deq_port = idx;
endmodule

// File: rtl/voq_freelist.sv
module voq_freelist #(
  parameter int NSLOT = 32,
  parameter int SW    = 5,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [SW-1:0] push_idx,
  output logic [SW-1:0] top_idx,
  output logic          avail
);
  logic [SW-1:0] ring [NSLOT];
  logic [SW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;

  function automatic logic [SW-1:0] wrap_inc(input logic [SW-1:0] p);
    return (p == SW'(NSLOT-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_n  = pop  ? wrap_inc(rd_q) : rd_q;
    wr_n  = push ? wrap_inc(wr_q) : wr_q;
    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(NSLOT);
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) ring[i] <= SW'(i);
    end else if (push) begin
      ring[wr_q] <= push_idx;
    end
  end

  assign top_idx = ring[rd_q];
  assign avail   = (cnt_q != '0);
endmodule

// File: rtl/voq_linkq.sv
module voq_linkq #(
  parameter int NPORT = 4,
  parameter int NSLOT = 32,
  parameter int PW    = 2,
  parameter int SW    = 5,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq,
  input  logic [PW-1:0]    enq_port,
  input  logic [SW-1:0]    enq_slot,
  input  logic             deq,
  input  logic [PW-1:0]    deq_port,
  output logic [SW-1:0]    head_slot,
  output logic [NPORT-1:0] nonempty
);
  logic [SW-1:0] head_q [NPORT];
  logic [SW-1:0] head_n [NPORT];
  logic [SW-1:0] tail_q [NPORT];
  logic [SW-1:0] tail_n [NPORT];
  logic [CW-1:0] cnt_q  [NPORT];
  logic [CW-1:0] cnt_n  [NPORT];
  logic [SW-1:0] link   [NSLOT];
  logic          link_we;

  always_comb begin
    for (int q = 0; q < NPORT; q++) begin
      logic dq, eq, empty_after;
      dq = deq && (deq_port == PW'(q));
      eq = enq && (enq_port == PW'(q));
      empty_after = (cnt_q[q] == '0) || (dq && (cnt_q[q] == CW'(1)));
      cnt_n[q]  = cnt_q[q] + CW'(eq) - CW'(dq);
      head_n[q] = head_q[q];
      tail_n[q] = tail_q[q];
      if (eq && empty_after)
        head_n[q] = enq_slot;
      else if (dq)
        head_n[q] = link[head_q[q]];
      if (eq)
        tail_n[q] = enq_slot;
    end
  end

  // chain the new slot behind the old tail only if that tail stays live
  always_comb begin
    link_we = 1'b0;
    if (enq) begin
      if (deq && (deq_port == enq_port))
        link_we = (cnt_q[enq_port] > CW'(1));
      else
        link_we = (cnt_q[enq_port] != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NPORT; q++) begin
        head_q[q] <= '0;
        tail_q[q] <= '0;
        cnt_q[q]  <= '0;
      end
    end else begin
      for (int q = 0; q < NPORT; q++) begin
        head_q[q] <= head_n[q];
        tail_q[q] <= tail_n[q];
        cnt_q[q]  <= cnt_n[q];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (link_we) link[tail_q[enq_port]] <= enq_slot;
  end

  assign head_slot = head_q[deq_port];

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_ne
      assign nonempty[g] = (cnt_q[g] != '0);
    end
  endgenerate
endmodule

// File: rtl/voq_cellmem.sv
module voq_cellmem #(
  parameter int NSLOT  = 32,
  parameter int CELL_W = 64,
  parameter int SW     = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SW-1:0]     waddr,
  input  logic [CELL_W-1:0] wdata,
  input  logic [SW-1:0]     raddr,
  output logic [CELL_W-1:0] rdata
);
  logic [CELL_W-1:0] store [NSLOT];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/voq_buf.sv
module voq_buf #(
  parameter int NPORT  = voq_pkg::VOQ_DEF_PORTS,
  parameter int CELL_W = voq_pkg::VOQ_DEF_CELLW,
  parameter int NSLOT  = voq_pkg::VOQ_DEF_SLOTS,
  localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CW    = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PW-1:0]     in_port,
  input  logic [CELL_W-1:0] in_cell,
  output logic              in_ready,
  output logic [NPORT-1:0]  req,
  input  logic [NPORT-1:0]  grant,
  output logic              out_valid,
  output logic [PW-1:0]     out_port,
  output logic [CELL_W-1:0] out_cell
);
  logic          enq, deq;
  logic [PW-1:0] deq_port;
  logic [SW-1:0] free_slot, head_slot;

  assign enq = in_valid && in_ready;

  voq_grant_dec #(.NPORT(NPORT), .PW(PW)) u_gnt (
    .grant    (grant),
    .nonempty (req),
    .deq      (deq),
    .deq_port (deq_port)
  );

  voq_freelist #(.NSLOT(NSLOT), .SW(SW), .CW(CW)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (enq),
    .push     (deq),
    .push_idx (head_slot),
    .top_idx  (free_slot),
    .avail    (in_ready)
  );

  voq_linkq #(.NPORT(NPORT), .NSLOT(NSLOT), .PW(PW), .SW(SW), .CW(CW)) u_lq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq       (enq),
    .enq_port  (in_port),
    .enq_slot  (free_slot),
    .deq       (deq),
    .deq_port  (deq_port),
    .head_slot (head_slot),
    .nonempty  (req)
  );

  voq_cellmem #(.NSLOT(NSLOT), .CELL_W(CELL_W), .SW(SW)) u_mem (
    .clk   (clk),
    .we    (enq),
    .waddr (free_slot),
    .wdata (in_cell),
    .raddr (head_slot),
    .rdata (out_cell)
  );

  assign out_valid = deq;
  assign out_port  = deq_port;
endmodule

// File: rtl/voq_buf_chk.sv
module voq_buf_chk #(
  parameter int NPORT = 4,
  parameter int NSLOT = 32,
  parameter int PW    = 2,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PW-1:0]    in_port,
  input logic             in_ready,
  input logic [NPORT-1:0] req,
  input logic [NPORT-1:0] grant,
  input logic             out_valid,
  input logic [PW-1:0]    out_port
);
  logic          acc;
  logic [CW-1:0] occ;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + CW'(acc) - CW'(out_valid);
  end

  // R7
  ready_matches_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (occ != CW'(NSLOT)));

  // R2
  enq_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> req[$past(in_port)]);

  // R5
  bad_grant_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(grant) != 1 || (grant & req) == '0) |-> !out_valid);

  // R4
  out_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (grant[out_port] && req[out_port]));

  // R5
  idle_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !acc) |=> $stable(req));
endmodule

bind voq_buf voq_buf_chk #(.NPORT(NPORT), .NSLOT(NSLOT), .PW(PW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_port   (in_port),
  .in_ready  (in_ready),
  .req       (req),
  .grant     (grant),
  .out_valid (out_valid),
  .out_port  (out_port)
);

// File: tb/voq_buf_test.sv
`timescale 1ns/1ps
module voq_buf_test;
  localparam int NP = 4;
  localparam int CWD = 64;
  localparam int NS = 32;

  logic            clk, rst_n;
  logic            in_valid;
  logic [1:0]      in_port;
  logic [CWD-1:0]  in_cell;
  logic            in_ready;
  logic [NP-1:0]   req;
  logic [NP-1:0]   grant;
  logic            out_valid;
  logic [1:0]      out_port;
  logic [CWD-1:0]  out_cell;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [CWD-1:0] mq [NP][$];
  int seq = 0;

  voq_buf #(.NPORT(NP), .CELL_W(CWD), .NSLOT(NS)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
    .in_cell(in_cell), .in_ready(in_ready), .req(req), .grant(grant),
    .out_valid(out_valid), .out_port(out_port), .out_cell(out_cell)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [CWD-1:0] act,
                     input logic [CWD-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int total();
    int t = 0;
    for (int k = 0; k < NP; k++) t += mq[k].size();
    return t;
  endfunction

  function automatic logic [CWD-1:0] mkcell(input int p);
    return {8'(p), 24'hA5C3E1, 32'(seq)};
  endfunction

  // one clock cycle: drive after negedge, judge combinational outputs, commit model
  task automatic cyc(input bit v, input int p, input logic [NP-1:0] g, input string tag);
    logic [NP-1:0] exp_req;
    bit exp_rdy, acc, exp_ov;
    int gk, ones;
    logic [CWD-1:0] c;
    c = mkcell(p);
    seq++;
    in_valid = v; in_port = 2'(p); in_cell = c; grant = g;
    #2;
    exp_rdy = (total() < NS);
    exp_req = '0;
    for (int k = 0; k < NP; k++) exp_req[k] = (mq[k].size() != 0);
    ones = 0; gk = 0;
    for (int k = 0; k < NP; k++) if (g[k]) begin ones++; gk = k; end
    exp_ov = (ones == 1) && (mq[gk].size() != 0);
    chk(in_ready == exp_rdy, "R7 in_ready", CWD'(in_ready), CWD'(exp_rdy));
    chk(req == exp_req, "R2 req", CWD'(req), CWD'(exp_req));
    chk(out_valid == exp_ov, {tag, " out_valid"}, CWD'(out_valid), CWD'(exp_ov));
    if (exp_ov && out_valid) begin
      chk(out_port == 2'(gk), "R4 out_port", CWD'(out_port), CWD'(gk));
      chk(out_cell == mq[gk][0], {tag, " R3 out_cell"}, out_cell, mq[gk][0]);
    end
    acc = v && exp_rdy;
    @(posedge clk);
    if (exp_ov) void'(mq[gk].pop_front());
    if (acc) mq[p].push_back(c);
    @(negedge clk);
  endtask

  function automatic logic [NP-1:0] oh(input int k);
    return NP'(1) << k;
  endfunction

  task automatic drain_all(input string tag);
    for (int k = 0; k < NP; k++)
      while (mq[k].size() != 0) cyc(0, 0, oh(k), tag);
  endtask

  logic [15:0] lfsr;

  initial begin
    rst_n = 0; in_valid = 0; in_port = 0; in_cell = 0; grant = 0;
    #35;
    // R1: reset state
    chk(req == '0, "R1 req", CWD'(req), 0);
    chk(in_ready == 1'b1, "R1 in_ready", CWD'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", CWD'(out_valid), 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R2, R3, R4: three cells per output, then drain each in order
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < NP; k++) cyc(1, k, '0, "R2");
    for (int k = NP - 1; k >= 0; k--)
      for (int r = 0; r < 3; r++) cyc(0, 0, oh(k), "R4");
    cyc(0, 0, '0, "R1");

    // R5: zero, multi-hot and empty-queue grants remove nothing
    cyc(1, 2, '0, "R5"); cyc(1, 2, '0, "R5");
    cyc(0, 0, 4'b0000, "R5");
    cyc(0, 0, 4'b0110, "R5");
    cyc(0, 0, 4'b1111, "R5");
    cyc(0, 0, 4'b0001, "R5");
    cyc(0, 0, 4'b1000, "R5");
    drain_all("R5");

    // R6: queue 0 held back, others served
    for (int r = 0; r < 8; r++) cyc(1, 0, '0, "R6");
    for (int r = 0; r < 12; r++) cyc(1, 1 + (r % 3), (r > 0) ? oh(1 + ((r - 1) % 3)) : '0, "R6");
    for (int k = 1; k < NP; k++)
      while (mq[k].size() != 0) cyc(0, 0, oh(k), "R6");
    chk(req == 4'b0001, "R6 req only q0", CWD'(req), 1);
    drain_all("R6");

    // R8: same-queue enqueue and grant at one cell and at zero cells
    cyc(1, 3, '0, "R8");
    cyc(1, 3, oh(3), "R8");
    cyc(1, 3, oh(3), "R8");
    cyc(0, 0, oh(3), "R8");
    cyc(1, 1, oh(1), "R8");
    cyc(1, 0, oh(1), "R8");
    cyc(1, 2, oh(0), "R8");
    drain_all("R8");

    // R7: fill all slots, offers while full are dropped
    for (int r = 0; r < NS; r++) cyc(1, r % NP, '0, "R7");
    chk(in_ready == 1'b0, "R7 full", CWD'(in_ready), 0);
    for (int r = 0; r < 4; r++) cyc(1, r, '0, "R7");
    // R8 at the free-list edge: grant while full with an offer, then refill
    cyc(1, 1, oh(2), "R8");
    cyc(1, 1, oh(0), "R8");
    drain_all("R7");

    // R9: random mix, then refill exactly NSLOT cells
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] g;
      bit v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = (i % 600 < 300) ? (lfsr[3:0] < 13) : (lfsr[3:0] < 5);
      case (lfsr[6:5])
        2'd0: g = lfsr[10:7] & 4'hF;
        default: g = oh(int'(lfsr[12:11]));
      endcase
      cyc(v, int'(lfsr[9:8]), g, "R8");
    end
    drain_all("R9");
    for (int r = 0; r < NS; r++) cyc(1, (r * 3) % NP, '0, "R9");
    chk(in_ready == 1'b0, "R9 refill full", CWD'(in_ready), 0);
    drain_all("R9");
    cyc(0, 0, '0, "R9");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule